// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block receives characters over a half-duplex synchronous serial link on which an external master drives the clock. The external clock and the data pin are brought into the system clock domain through a two-flop synchroniser. A falling edge of the synchronised clock samples one data bit, least significant bit first. When 8 bits have arrived, or 9 bits in nine-bit mode, the character moves into a two-entry receive FIFO and a data-available flag rises.

The host reads the low byte of the head entry from the data output and the ninth bit from a separate output. A pop strobe removes the head entry. The available flag, gated by an interrupt enable, drives an interrupt output. Reception needs no system activity beyond the clock, so this output can serve as a wake request for a host that is asleep.

Reception runs only when three conditions hold: the port is enabled, synchronous mode is selected, and clock-master mode is off. It then runs continuously for as long as the continuous-receive enable is high. A single-shot receive request input exists but has no effect in this mode. If a character completes while the FIFO is full, the receiver raises a sticky overrun flag, which only turning continuous receive off clears.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, `rx_avail_o`, `overrun_o` and `rx_irq_o` are all 0.
- R2: In 8-bit mode (`nine_bit_i`=0), a bit is sampled on each falling edge of `ext_clk_i`, and the first bit received is bit 0. After 8 falling edges the character appears on `rx_data_o`, with `rx_bit8_o`=0.
- R3: In 9-bit mode (`nine_bit_i`=1), a character is 9 bits long, LSB first. Bits 7..0 appear on `rx_data_o` and bit 8 appears on `rx_bit8_o`.
- R4: While enabled, the receiver never idles. Characters sent back to back with no gap are each received intact and in order.
- R5: `single_rx_req_i` has no effect. With `cont_rx_en_i`=0, no character is received whatever its value, and `rx_avail_o` does not change without a pop.
- R6: `rx_avail_o` is 1 while the FIFO holds at least one entry and stays 1 until a pop empties it. A pulse on `rd_pop_i` removes the head entry.
- R7: `rx_irq_o` is 1 exactly when `rx_avail_o` and `rx_int_en_i` are both 1.
- R8: The FIFO holds two characters. A character that completes while the FIFO is full is discarded and sets `overrun_o`. While `overrun_o` is 1, no further character enters the FIFO.
- R9: `overrun_o` stays set until `cont_rx_en_i` is 0. Deasserting `cont_rx_en_i` clears `overrun_o` and discards a partly received character, and it keeps the FIFO contents.
- R10: Reception requires `port_en_i`=1, `sync_mode_i`=1 and `clk_master_i`=0. With `clk_master_i`=1, clock edges receive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enable |
| sync_mode_i | input | 1 | Synchronous mode select |
| clk_master_i | input | 1 | Clock-master select; must be 0 to receive |
| cont_rx_en_i | input | 1 | Continuous receive enable; low clears overrun |
| nine_bit_i | input | 1 | 9-bit character mode |
| single_rx_req_i | input | 1 | Single-shot receive request (ignored) |
| rx_int_en_i | input | 1 | Receive interrupt enable |
| ext_clk_i | input | 1 | Serial clock from the external master |
| ser_data_i | input | 1 | Serial data pin |
| rd_pop_i | input | 1 | Pop the FIFO head entry |
| rx_data_o | output | 8 | Low byte of the FIFO head entry |
| rx_bit8_o | output | 1 | Ninth bit of the FIFO head entry |
| rx_avail_o | output | 1 | FIFO not empty (receive complete) |
| overrun_o | output | 1 | Sticky overrun error |
| rx_irq_o | output | 1 | Receive interrupt / wake request |

## Verification
The assertions check the following on every cycle:
- the interrupt is never raised without data;
- the available flag does not drop without a pop;
- the available flag stays stable while reception is off;
- overrun rises only with data still held;
- overrun persists only under continuous receive and is cleared once that enable falls.

Only the bench's scenarios can show the following:
- bit order;
- ninth-bit placement;
- back-to-back character integrity;
- the discarding of a third character and of characters received during overrun;
- the loss of a partial character when the enable is dropped;
- the lack of reception under master-clock selection.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned CHAR_W = 9;
  typedef struct packed {
    logic       bit8;
    logic [7:0] data;
  } rx_char_t;
endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic ext_dat_i,
  output logic fall_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_pipe_q, dat_pipe_q;
  logic              clk_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          clk_pipe_q <= '0;
          dat_pipe_q <= '0;
        end else begin
          clk_pipe_q <= ext_clk_i;
          dat_pipe_q <= ext_dat_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          clk_pipe_q <= '0;
          dat_pipe_q <= '0;
        end else begin
          clk_pipe_q <= {clk_pipe_q[STAGES-2:0], ext_clk_i};
          dat_pipe_q <= {dat_pipe_q[STAGES-2:0], ext_dat_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= 1'b0;
    else         clk_prev_q <= clk_pipe_q[STAGES-1];
  end

  assign fall_o = clk_prev_q & ~clk_pipe_q[STAGES-1];
  assign dat_o  = dat_pipe_q[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int unsigned CHAR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic              nine_i,
  output logic              done_o,
  output logic [CHAR_W-1:0] char_o
);
  localparam int unsigned CNT_W = $clog2(CHAR_W + 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(CHAR_W - 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(CHAR_W - 2);

  logic [CNT_W-1:0]  cnt_q, last;
  logic [CHAR_W-1:0] sr_q, sr_nxt;

  assign last = nine_i ? LAST9 : LAST8;

  always_comb begin
    sr_nxt = sr_q;
    for (int i = 0; i < int'(CHAR_W); i++)
      if (cnt_q == CNT_W'(i)) sr_nxt[i] = din_i;
  end

  // >= guards a mode change from 9 to 8 bits mid-character
  assign done_o = fall_i & ~clear_i & (cnt_q >= last);
  assign char_o = sr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (clear_i || done_o) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (fall_i) begin
      cnt_q <= cnt_q + 1'b1;
      sr_q  <= sr_nxt;
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic             full_o,
  output logic             empty_o,
  output logic [WIDTH-1:0] head_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q <= (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
      end
      if (pop_i) rd_q <= (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int unsigned FIFO_DEPTH  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       port_en_i,
  input  logic       sync_mode_i,
  input  logic       clk_master_i,
  input  logic       cont_rx_en_i,
  input  logic       nine_bit_i,
  input  logic       single_rx_req_i,
  input  logic       rx_int_en_i,
  input  logic       ext_clk_i,
  input  logic       ser_data_i,
  input  logic       rd_pop_i,
  output logic [7:0] rx_data_o,
  output logic       rx_bit8_o,
  output logic       rx_avail_o,
  output logic       overrun_o,
  output logic       rx_irq_o
);
  import srx_pkg::*;

  logic                active, fall, din, done, full, empty, push, pop, ovr_q;
  logic [CHAR_W-1:0]   char_w;
  rx_char_t            head;

  // single-shot request has no role in slave mode
  logic unused_req;
  assign unused_req = single_rx_req_i;

  assign active = port_en_i & sync_mode_i & ~clk_master_i & cont_rx_en_i;

  srx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_clk_i (ext_clk_i),
    .ext_dat_i (ser_data_i),
    .fall_o    (fall),
    .dat_o     (din)
  );

  srx_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (~active),
    .fall_i  (fall),
    .din_i   (din),
    .nine_i  (nine_bit_i),
    .done_o  (done),
    .char_o  (char_w)
  );

  assign push = done & ~full & ~ovr_q;
  assign pop  = rd_pop_i & ~empty;

  srx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (char_w),
    .pop_i   (pop),
    .full_o  (full),
    .empty_o (empty),
    .head_o  (head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ovr_q <= 1'b0;
    else if (!cont_rx_en_i) ovr_q <= 1'b0;
    else if (done && full)  ovr_q <= 1'b1;
  end

  assign rx_data_o  = head.data;
  assign rx_bit8_o  = head.bit8;
  assign rx_avail_o = ~empty;
  assign overrun_o  = ovr_q;
  assign rx_irq_o   = ~empty & rx_int_en_i;
endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cont_rx_en_i,
  input logic rd_pop_i,
  input logic rx_avail_o,
  input logic overrun_o,
  input logic rx_irq_o
);
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_avail_o); // R7
  AST_AVAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_avail_o && !rd_pop_i) |=> rx_avail_o); // R6
  AST_OFF_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_rx_en_i && !rd_pop_i) |=> $stable(rx_avail_o)); // R5
  AST_OVR_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> rx_avail_o); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && cont_rx_en_i) |=> overrun_o); // R9
  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont_rx_en_i |=> !overrun_o); // R9
endmodule

bind sync_slave_rx sync_slave_rx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cont_rx_en_i (cont_rx_en_i),
  .rd_pop_i     (rd_pop_i),
  .rx_avail_o   (rx_avail_o),
  .overrun_o    (overrun_o),
  .rx_irq_o     (rx_irq_o)
);

// File: tb/sync_slave_rx_tb.sv
module sync_slave_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 0, sync_mode = 0, clk_master = 0, cont_en = 0, nine = 0;
  logic single_req = 0, int_en = 0, ext_clk = 1, ser_dat = 0, rd_pop = 0;
  logic [7:0] rx_data;
  logic rx_bit8, rx_avail, ovr, irq;

  int n_chk = 0, n_fail = 0, n_rx = 0;
  bit auto_pop = 0, done = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sync_slave_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .sync_mode_i(sync_mode),
    .clk_master_i(clk_master), .cont_rx_en_i(cont_en), .nine_bit_i(nine),
    .single_rx_req_i(single_req), .rx_int_en_i(int_en), .ext_clk_i(ext_clk),
    .ser_data_i(ser_dat), .rd_pop_i(rd_pop), .rx_data_o(rx_data),
    .rx_bit8_o(rx_bit8), .rx_avail_o(rx_avail), .overrun_o(ovr), .rx_irq_o(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_cyc(3);
    ext_clk = 1'b0;
    wait_cyc(4);
    ext_clk = 1'b1;
    wait_cyc(1);
  endtask

  // driver: shifts a character LSB first, queues it when it must be received
  task automatic send_char(input logic [8:0] ch, input int nbits, input bit expect_it, input string tag);
    if (expect_it) begin
      exp_q.push_back(ch);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < nbits; i++) send_bit(ch[i]);
  endtask

  // monitor: pops the FIFO and compares against the queue
  always @(negedge clk) begin
    if (rd_pop) rd_pop = 1'b0;
    else if (auto_pop && rx_avail && rst_n) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected char", {rx_bit8, rx_data}, 0);
      else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rx_bit8, rx_data} == e, t, {rx_bit8, rx_data}, e);
        n_rx++;
      end
      rd_pop = 1'b1;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check(rx_avail == 0, "R1 avail", rx_avail, 0);
    check(ovr == 0, "R1 overrun", ovr, 0);
    check(irq == 0, "R1 irq", irq, 0);

    port_en = 1; sync_mode = 1; cont_en = 1; auto_pop = 1;
    send_char(9'h0A5, 8, 1, "R2 lsb first");
    send_char(9'h03C, 8, 1, "R4 back to back");
    send_char(9'h0FF, 8, 1, "R4 back to back");
    send_char(9'h000, 8, 1, "R4 back to back");
    wait_cyc(10);
    check(n_rx == 4 && exp_q.size() == 0, "R4 count", n_rx, 4);

    nine = 1;
    send_char(9'h1A5, 9, 1, "R3 ninth bit set");
    send_char(9'h05A, 9, 1, "R3 ninth bit clear");
    wait_cyc(10);
    nine = 0;
    check(n_rx == 6, "R3 count", n_rx, 6);

    auto_pop = 0; int_en = 1;
    send_char(9'h081, 8, 1, "R6 pop data");
    wait_cyc(6);
    check(rx_avail == 1, "R6 avail set", rx_avail, 1);
    check(irq == 1, "R7 irq on", irq, 1);
    int_en = 0;
    wait_cyc(1);
    check(irq == 0, "R7 irq masked", irq, 0);
    auto_pop = 1;
    wait_cyc(6);
    check(rx_avail == 0, "R6 avail cleared", rx_avail, 0);

    auto_pop = 0;
    send_char(9'h011, 8, 1, "R8 first kept");
    send_char(9'h022, 8, 1, "R8 second kept");
    check(ovr == 0, "R8 no overrun yet", ovr, 0);
    send_char(9'h033, 8, 0, "");
    wait_cyc(4);
    check(ovr == 1, "R8 overrun set", ovr, 1);
    send_char(9'h044, 8, 0, "");
    auto_pop = 1;
    wait_cyc(10);
    check(rx_avail == 0, "R8 third discarded", rx_avail, 0);
    auto_pop = 0;
    send_char(9'h055, 8, 0, "");
    wait_cyc(6);
    check(rx_avail == 0, "R8 blocked in overrun", rx_avail, 0);
    check(ovr == 1, "R9 overrun sticky", ovr, 1);

    cont_en = 0;
    wait_cyc(2);
    check(ovr == 0, "R9 overrun cleared", ovr, 0);
    cont_en = 1;
    send_char(9'h066, 8, 1, "R9 retained");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    cont_en = 0;
    wait_cyc(4);
    check(rx_avail == 1 && rx_data == 8'h66, "R9 fifo kept", rx_data, 8'h66);
    cont_en = 1;
    send_char(9'h099, 8, 1, "R9 partial dropped");
    auto_pop = 1;
    wait_cyc(12);

    cont_en = 0; single_req = 1; auto_pop = 0;
    send_char(9'h077, 8, 0, "");
    wait_cyc(6);
    check(rx_avail == 0, "R5 single request ignored", rx_avail, 0);
    cont_en = 1; clk_master = 1;
    send_char(9'h077, 8, 0, "");
    wait_cyc(6);
    check(rx_avail == 0, "R10 master mode", rx_avail, 0);
    clk_master = 0; auto_pop = 1;
    send_char(9'h042, 8, 1, "R5 request no effect");
    wait_cyc(12);
    check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule